// File: doc/BRIEF.md
# Prioritised interrupt level and vector encoder

This block merges thirteen interrupt request lines, numbered 1 to 13, into one interrupt level and one vector number for the processor. A pending register copies the request lines on every clock. A mask register blocks individual lines. Each line has an 8-bit control register. Bits 4:0 of that register hold a priority, and bits 4:2 of the same field are the interrupt level. Bit 7 selects autovectoring.

On every clock the encoder finds the unmasked pending line with the largest priority. On a tie the lower-numbered line wins. If the winning priority is below 4, which is level 0, the outputs are driven to zero. Otherwise the level comes from the winner's control register. The vector is either 24 plus the level, or a number taken from one of three programmable vector registers. The level and vector outputs are registered.

Software reaches the registers through a single-cycle write strobe with an address and data bus. A combinational read port returns the register selected by the address.

Top module: `irq_prio_enc`

## Requirements
- R1: The pending register captures `req_i` on every clock edge. It reads back at address 0x11 as bit n for line n, with bits 0, 14 and 15 reading 0.
- R2: A line is active only when its pending bit is 1 and its mask bit is 0. The mask register is at address 0x10, bit n for line n. When no line is active, the level and vector outputs are 0.
- R3: Among active lines, the winner has the largest control bits 4:0. On equal values the lower-numbered line wins.
- R4: If the winner's bits 4:0 are below 4, the level and vector outputs are both 0.
- R5: Otherwise the level output equals bits 4:2 of the winner's control register.
- R6: If bit 7 of the winner's control register is 1, the vector output is 24 plus the level.
- R7: If bit 7 is 0, the vector comes from a register chosen by the winning line. Line 8 uses the watchdog vector register (address 0x12). Line 12 uses vector register A (0x13). Line 13 uses vector register B (0x14). Every other line gives 0x0F.
- R8: After reset the outputs are 0 and the mask reads 0x3FFE. The watchdog vector is 0x0F, and vector registers A and B are 0x00. Control registers are at addresses 1 to 13, one per line. Their reset values are 0x04, 0x08, 0x0C, 0x10, 0x14, 0x18 and 0x1C for lines 1 to 7, then 0x1C for line 8, 0x80 for lines 9 to 11, and 0x00 for lines 12 and 13.
- R9: A register write or a request change takes effect in the state at one clock edge. The level and vector outputs reflect it after the following edge and not earlier.
- R10: Writes to the pending address or to unmapped addresses change nothing. Reads of unmapped addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 13 | Request lines, index n is line n |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 6 | Register address |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for addr_i |
| level_o | output | 3 | Interrupt level to the processor |
| vector_o | output | 8 | Vector number to the processor |

## Verification
The encoder is tried with all requests masked, then with a single line, two lines tied on priority, and two lines that differ by one priority step. Together these separate the mask gate, the tie rule and the magnitude compare. A winner with priority 3 is compared against one with priority 4 to pin the level-0 cut-off. Autovectored and register-vectored winners on lines 7, 8, 12 and 13 tell the four vector sources apart. A write followed by a look at the outputs one edge and then two edges later fixes the output latency.

// File: rtl/irq_enc_pkg.sv
package irq_enc_pkg;
  localparam int NUM_SRC   = 13;
  localparam int CTRL_W    = 8;
  localparam int PRIO_W    = 5;
  localparam int LVL_W     = 3;
  localparam int VEC_W     = 8;
  localparam int ADDR_W    = 6;
  localparam int DATA_W    = 16;
  localparam int IDX_W     = $clog2(NUM_SRC + 1);

  localparam logic [ADDR_W-1:0] A_MASK = 6'h10;
  localparam logic [ADDR_W-1:0] A_PEND = 6'h11;
  localparam logic [ADDR_W-1:0] A_WDV  = 6'h12;
  localparam logic [ADDR_W-1:0] A_VA   = 6'h13;
  localparam logic [ADDR_W-1:0] A_VB   = 6'h14;

  localparam int SRC_WDOG = 8;
  localparam int SRC_VA   = 12;
  localparam int SRC_VB   = 13;

  localparam logic [VEC_W-1:0]  AUTO_BASE = 8'd24;
  localparam logic [VEC_W-1:0]  DEF_VEC   = 8'h0F;
  localparam logic [VEC_W-1:0]  WDV_RST   = 8'h0F;
  localparam logic [PRIO_W-1:0] MIN_PRIO  = 5'd4;

  function automatic logic [CTRL_W-1:0] ctrl_rst(input int n);
    if (n <= 7)       return CTRL_W'(n * 4);
    else if (n == 8)  return 8'h1C;
    else if (n <= 11) return 8'h80;
    else              return 8'h00;
  endfunction
endpackage

// File: rtl/irq_regs.sv
module irq_regs
  import irq_enc_pkg::*;
#(
  parameter int N = NUM_SRC
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [N:1]             req_i,
  input  logic                   wr_en_i,
  input  logic [ADDR_W-1:0]      addr_i,
  input  logic [DATA_W-1:0]      wdata_i,
  output logic [DATA_W-1:0]      rdata_o,
  output logic [N:1]             pend_o,
  output logic [N:1]             mask_o,
  output logic [N:1][CTRL_W-1:0] ctrl_o,
  output logic [VEC_W-1:0]       wdv_o,
  output logic [VEC_W-1:0]       va_o,
  output logic [VEC_W-1:0]       vb_o
);
  localparam int PAD_W = DATA_W - N - 1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_o <= '0;
      mask_o <= '1;
      wdv_o  <= WDV_RST;
      va_o   <= '0;
      vb_o   <= '0;
    end else begin
      pend_o <= req_i;
      if (wr_en_i) begin
        case (addr_i)
          A_MASK:  mask_o <= wdata_i[N:1];
          A_WDV:   wdv_o  <= wdata_i[VEC_W-1:0];
          A_VA:    va_o   <= wdata_i[VEC_W-1:0];
          A_VB:    vb_o   <= wdata_i[VEC_W-1:0];
          default: ;
        endcase
      end
    end
  end

  for (genvar n = 1; n <= N; n++) begin : g_ctrl
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        ctrl_o[n] <= ctrl_rst(n);
      else if (wr_en_i && addr_i == ADDR_W'(n))
        ctrl_o[n] <= wdata_i[CTRL_W-1:0];
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int n = 1; n <= N; n++)
      if (addr_i == ADDR_W'(n)) rdata_o = DATA_W'(ctrl_o[n]);
    case (addr_i)
      A_MASK:  rdata_o = {{PAD_W{1'b0}}, mask_o, 1'b0};
      A_PEND:  rdata_o = {{PAD_W{1'b0}}, pend_o, 1'b0};
      A_WDV:   rdata_o = DATA_W'(wdv_o);
      A_VA:    rdata_o = DATA_W'(va_o);
      A_VB:    rdata_o = DATA_W'(vb_o);
      default: ;
    endcase
  end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_enc_pkg::*;
#(
  parameter int N = NUM_SRC
) (
  input  logic [N:1]             act_i,
  input  logic [N:1][CTRL_W-1:0] ctrl_i,
  output logic [IDX_W-1:0]       win_idx_o,
  output logic [PRIO_W-1:0]      win_prio_o,
  output logic                   win_auto_o
);
  // strict compare: ties keep the lower-numbered line
  always_comb begin
    win_idx_o  = '0;
    win_prio_o = '0;
    win_auto_o = 1'b0;
    for (int n = 1; n <= N; n++) begin
      if (act_i[n] && ctrl_i[n][PRIO_W-1:0] > win_prio_o) begin
        win_idx_o  = IDX_W'(n);
        win_prio_o = ctrl_i[n][PRIO_W-1:0];
        win_auto_o = ctrl_i[n][CTRL_W-1];
      end
    end
  end
endmodule

// File: rtl/irq_vec_gen.sv
module irq_vec_gen
  import irq_enc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IDX_W-1:0]  win_idx_i,
  input  logic [PRIO_W-1:0] win_prio_i,
  input  logic              win_auto_i,
  input  logic [VEC_W-1:0]  wdv_i,
  input  logic [VEC_W-1:0]  va_i,
  input  logic [VEC_W-1:0]  vb_i,
  output logic [LVL_W-1:0]  level_o,
  output logic [VEC_W-1:0]  vector_o
);
  logic [LVL_W-1:0] lvl_d;
  logic [VEC_W-1:0] vec_d;

  always_comb begin
    lvl_d = '0;
    vec_d = '0;
    if (win_prio_i >= MIN_PRIO) begin
      lvl_d = win_prio_i[PRIO_W-1 -: LVL_W];
      if (win_auto_i)
        vec_d = AUTO_BASE + VEC_W'(lvl_d);
      else begin
        case (win_idx_i)
          IDX_W'(SRC_WDOG): vec_d = wdv_i;
          IDX_W'(SRC_VA):   vec_d = va_i;
          IDX_W'(SRC_VB):   vec_d = vb_i;
          default:          vec_d = DEF_VEC;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      level_o  <= '0;
      vector_o <= '0;
    end else begin
      level_o  <= lvl_d;
      vector_o <= vec_d;
    end
  end
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc
  import irq_enc_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_SRC:1]    req_i,
  input  logic                wr_en_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [DATA_W-1:0]   wdata_i,
  output logic [DATA_W-1:0]   rdata_o,
  output logic [LVL_W-1:0]    level_o,
  output logic [VEC_W-1:0]    vector_o
);
  logic [NUM_SRC:1]             pend, mask, act;
  logic [NUM_SRC:1][CTRL_W-1:0] ctrl;
  logic [VEC_W-1:0]             wdv, va, vb;
  logic [IDX_W-1:0]             win_idx;
  logic [PRIO_W-1:0]            win_prio;
  logic                         win_auto;

  irq_regs #(.N(NUM_SRC)) u_regs (
    .clk_i, .rst_ni, .req_i, .wr_en_i, .addr_i, .wdata_i, .rdata_o,
    .pend_o(pend), .mask_o(mask), .ctrl_o(ctrl),
    .wdv_o(wdv), .va_o(va), .vb_o(vb)
  );

  assign act = pend & ~mask;

  irq_arbiter #(.N(NUM_SRC)) u_arb (
    .act_i(act), .ctrl_i(ctrl),
    .win_idx_o(win_idx), .win_prio_o(win_prio), .win_auto_o(win_auto)
  );

  irq_vec_gen u_vec (
    .clk_i, .rst_ni,
    .win_idx_i(win_idx), .win_prio_i(win_prio), .win_auto_i(win_auto),
    .wdv_i(wdv), .va_i(va), .vb_i(vb),
    .level_o, .vector_o
  );
endmodule

// File: rtl/irq_enc_chk.sv
module irq_enc_chk
  import irq_enc_pkg::*;
(
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic [NUM_SRC:1]           req_i,
  input logic [NUM_SRC:1]           pend,
  input logic [NUM_SRC:1]           act,
  input logic [NUM_SRC:1][CTRL_W-1:0] ctrl,
  input logic [IDX_W-1:0]           win_idx,
  input logic [PRIO_W-1:0]          win_prio,
  input logic [LVL_W-1:0]           level_o,
  input logic [VEC_W-1:0]           vector_o
);
  logic win_ok, win_is_auto;

  // winner is active, nothing above it, nothing lower-numbered equal
  always_comb begin
    win_ok      = 1'b1;
    win_is_auto = 1'b0;
    for (int n = 1; n <= NUM_SRC; n++) begin
      if (win_idx == IDX_W'(n)) begin
        win_is_auto = ctrl[n][CTRL_W-1];
        if (!act[n]) win_ok = 1'b0;
      end
      if (act[n] && ctrl[n][PRIO_W-1:0] > win_prio) win_ok = 1'b0;
      if (act[n] && ctrl[n][PRIO_W-1:0] == win_prio && IDX_W'(n) < win_idx) win_ok = 1'b0;
    end
  end

  p_pend_follow_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> pend == $past(req_i));

  p_masked_quiet_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act == '0 |=> (level_o == '0 && vector_o == '0));

  p_winner_rank_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act != '0 |-> win_ok);

  p_low_cut_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_prio < MIN_PRIO |=> (level_o == '0 && vector_o == '0));

  p_level_src_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_prio >= MIN_PRIO |=> level_o == $past(win_prio[PRIO_W-1 -: LVL_W]));

  p_autovec_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (win_prio >= MIN_PRIO && win_is_auto) |=> vector_o == AUTO_BASE + VEC_W'(level_o));
endmodule

bind irq_prio_enc irq_enc_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .pend(pend), .act(act),
  .ctrl(ctrl), .win_idx(win_idx), .win_prio(win_prio),
  .level_o(level_o), .vector_o(vector_o)
);

// File: tb/irq_prio_enc_tb.sv
`timescale 1ns/1ps
module irq_prio_enc_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [13:1] req = '0;
  logic        wr_en = 1'b0;
  logic [5:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic [2:0]  level;
  logic [7:0]  vector;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  irq_prio_enc u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .wr_en_i(wr_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .level_o(level), .vector_o(vector)
  );

  // ---------------- reference model ----------------
  int m_ctrl[1:13];
  int m_mask, m_pend, m_wdv, m_va, m_vb;
  int exp_lvl, exp_vec;

  function automatic int rst_ctrl(int n);
    if (n <= 7) return 4 * n;
    if (n == 8) return 'h1C;
    if (n <= 11) return 'h80;
    return 0;
  endfunction

  task automatic model_out(output int l, output int v);
    int best, who;
    best = 0; who = 0;
    for (int n = 1; n <= 13; n++)
      if (((m_pend >> n) & 1) == 1 && ((m_mask >> n) & 1) == 0 && (m_ctrl[n] % 32) > best) begin
        best = m_ctrl[n] % 32; who = n;
      end
    l = 0; v = 0;
    if (best >= 4) begin
      l = best / 4;
      if (m_ctrl[who] >= 128) v = 24 + l;
      else if (who == 8) v = m_wdv;
      else if (who == 12) v = m_va;
      else if (who == 13) v = m_vb;
      else v = 15;
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int n = 1; n <= 13; n++) m_ctrl[n] = rst_ctrl(n);
      m_mask = 'h3FFE; m_pend = 0; m_wdv = 'h0F; m_va = 0; m_vb = 0;
      exp_lvl = 0; exp_vec = 0;
    end else begin
      model_out(exp_lvl, exp_vec);
      m_pend = int'(req) << 1;
      if (wr_en) begin
        if (addr >= 1 && addr <= 13) m_ctrl[addr] = wdata & 'hFF;
        else if (addr == 6'h10) m_mask = wdata & 'h3FFE;
        else if (addr == 6'h12) m_wdv = wdata & 'hFF;
        else if (addr == 6'h13) m_va = wdata & 'hFF;
        else if (addr == 6'h14) m_vb = wdata & 'hFF;
      end
    end
  end

  // cycle-by-cycle comparison (R9 latency, all output rules)
  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if (level !== 3'(exp_lvl) || vector !== 8'(exp_vec)) begin
        errors++;
        $display("FAIL R9 model compare: level=%0d vector=%0h expected level=%0d vector=%0h",
                 level, vector, exp_lvl, exp_vec);
      end
    end
  end

  // ---------------- helpers ----------------
  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(int a, int d);
    @(posedge clk); #1;
    wr_en = 1'b1; addr = 6'(a); wdata = 16'(d);
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic rd(int a, int exp, string tag);
    @(posedge clk); #1;
    addr = 6'(a);
    @(negedge clk);
    chk(tag, rdata, exp);
  endtask

  task automatic settle();
    repeat (2) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic out_is(int l, int v, string tag);
    chk({tag, " level"}, level, l);
    chk({tag, " vector"}, vector, v);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog expired: actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    out_is(0, 0, "R8 reset outputs");
    rd('h10, 'h3FFE, "R8 mask reset");
    rd(1, 'h04, "R8 ctrl1 reset");
    rd(8, 'h1C, "R8 ctrl8 reset");
    rd(9, 'h80, "R8 ctrl9 reset");
    rd(13, 'h00, "R8 ctrl13 reset");
    rd('h12, 'h0F, "R8 watchdog vector reset");
    rd('h13, 'h00, "R8 vector A reset");

    // all requests, all masked
    @(posedge clk); #1 req = '1;
    settle();
    out_is(0, 0, "R2 all masked");
    rd('h11, 'h3FFE, "R1 pending readback");

    // line 7 alone: level 7, default vector
    wr('h10, 'h3F7E);
    settle();
    out_is(7, 'h0F, "R5 R7 line 7 default vector");

    // tie 7 vs 8, lower wins
    wr('h12, 'h40);
    wr('h10, 'h3E7E);
    settle();
    out_is(7, 'h0F, "R3 tie lower line wins");
    wr(7, 'h10);
    settle();
    out_is(7, 'h40, "R7 line 8 watchdog vector");

    // threshold at priority 4
    wr('h10, 'h3FFC);
    settle();
    out_is(1, 'h0F, "R4 priority 4 gives level 1");
    wr(1, 'h03);
    settle();
    out_is(0, 0, "R4 priority 3 suppressed");

    // autovector on line 9
    wr('h10, 'h3DFE);
    settle();
    out_is(0, 0, "R4 ctrl 0x80 gives level 0");
    wr(9, 'h94);
    settle();
    out_is(5, 29, "R6 autovector 24+5");

    // lines 12 and 13
    wr('h13, 'h55);
    wr('h14, 'h66);
    wr(12, 'h18);
    wr('h10, 'h2FFE);
    settle();
    out_is(6, 'h55, "R7 line 12 vector A");
    wr(13, 'h19);
    wr('h10, 'h0FFE);
    settle();
    out_is(6, 'h66, "R3 larger priority wins, R7 vector B");

    // latency: write edge E, unchanged at E, new after E+1
    wr(13, 'h1D);
    @(negedge clk);
    out_is(6, 'h66, "R9 old value one edge after write");
    @(posedge clk); @(negedge clk);
    out_is(7, 'h66, "R9 new value two edges after write");

    // ignored writes
    wr('h11, 'h0000);
    rd('h11, 'h3FFE, "R10 pending write ignored");
    wr('h3F, 'hFFFF);
    rd('h3F, 0, "R10 unmapped read zero");
    rd('h10, 'h0FFE, "R10 mask untouched");
    settle();
    out_is(7, 'h66, "R10 outputs unchanged");

    // drop requests
    @(posedge clk); #1 req = '0;
    settle();
    out_is(0, 0, "R1 R2 requests released");
    rd('h11, 0, "R1 pending cleared");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule